// File: doc/BRIEF.md
# Row-Buffered Page-Mode Byte Memory

This block is a clock-synchronous model of a byte-wide memory with an SRAM-like pin set: a pair of chip selects of opposite polarity, an output enable, a write enable, an address and a byte of data. Storage is split into rows of eight bytes. The block keeps one row open at a time. Bytes inside the open row are reached with a short page latency. Touching a different row closes the open one, waits out a precharge interval and then reopens. Releasing the chip select has the same effect.

Every row opening raises a one-cycle strobe that carries the row number. Logic outside the block can use it to count wear per row. Read data comes with a valid flag that marks the cycle in which the byte may be taken. The address width is a parameter. `ADDR_W = 17` gives the full 16384 rows of 8 bytes. The default is a smaller array so that the model stays light in generic builds.

Top module: `rowbuf_mem`

## Requirements
- R1: After reset no row is open, and `data_valid`, `act_stb` and `rdata` are low. The first selected read then needs `ROW_ACCESS_CYCLES` clock edges before `data_valid` rises.
- R2: The chip counts as selected only when `ce_n` is 0 and `ce` is 1. Any other combination starts no row opening.
- R3: `addr[ADDR_W-1:3]` names the row and `addr[2:0]` names the byte within it. `act_row` reports the row that was opened.
- R4: Releasing the select while a row is open starts a precharge of `PRECHARGE_CYCLES` edges. A select that returns before the precharge ends opens nothing until it has run out.
- R5: A row change while selected closes the open row and precharges. The row is then reopened. For a read, `data_valid` rises `PRECHARGE_CYCLES + ROW_ACCESS_CYCLES` edges after the new address is first sampled.
- R6: In the open row, a change of only `addr[2:0]` yields valid data after `PAGE_ACCESS_CYCLES` edges. It causes no precharge and no `act_stb`, whatever the byte order.
- R7: `act_stb` is high for exactly one cycle per row opening. Two openings are always at least `PRECHARGE_CYCLES + 1` cycles apart.
- R8: A write stores `wdata` at an edge where the chip is selected, `we_n` is 0, the addressed byte's row is open and its latency has elapsed. While `we_n` is 0, `oe_n` is ignored and `data_valid` stays low.
- R9: `rdata_oe` is 1 exactly when the chip is selected, `oe_n` is 0 and `we_n` is 1.
- R10: `data_valid` rises only after an edge that sampled a read on the open row with its latency done. `rdata` then holds the stored byte at the address. At all other times `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| ce | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: row in the upper bits, byte in the low three bits |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not valid |
| rdata_oe | output | 1 | Output-drive enable for the external data bus |
| data_valid | output | 1 | Read data on `rdata` is valid |
| act_stb | output | 1 | One-cycle pulse on each row opening |
| act_row | output | ADDR_W-3 | Row number of the latest opening |

## Verification
The hardest case to reach is a select that returns while a precharge is still running. Only a gap shorter than `PRECHARGE_CYCLES` shows whether the block holds off the new opening instead of starting at once. The stimulus releases the select for a single cycle and then reads at once. It also forces row changes in the middle of a write stream. In both cases the measured latency is compared against the combined precharge and row delay. Non-sequential byte orders in one row show that page hits never pulse the activation strobe.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

    localparam int COL_BITS = 3;

    typedef enum logic [1:0] {
        PH_CLOSED = 2'd0,
        PH_PRECH  = 2'd1,
        PH_OPEN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } req_t;

    function automatic req_t decode_req(input logic ce_n, input logic ce,
                                        input logic oe_n, input logic we_n);
        req_t r;
        r.sel = !ce_n && ce;
        r.wr  = r.sel && !we_n;
        r.rd  = r.sel && we_n && !oe_n;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rowbuf_array.sv
module rowbuf_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= wdata;
        end
        rd_q <= store[addr];
    end
endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
    import rowbuf_pkg::*;
#(
    parameter int ROW_W              = 8,
    parameter int PRECHARGE_CYCLES   = 3,
    parameter int ROW_ACCESS_CYCLES  = 2,
    parameter int PAGE_ACCESS_CYCLES = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  req_t                req,
    input  logic [ROW_W-1:0]    row_in,
    input  logic [COL_BITS-1:0] col_in,
    output logic                wr_en,
    output logic                data_valid,
    output logic                act_stb,
    output logic [ROW_W-1:0]    act_row
);
    localparam int CNT_W = $clog2(max3(PRECHARGE_CYCLES, ROW_ACCESS_CYCLES,
                                       PAGE_ACCESS_CYCLES) + 1);
    localparam logic [CNT_W-1:0] PRE_LOAD  = CNT_W'(PRECHARGE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ROW_LOAD  = CNT_W'(ROW_ACCESS_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_ACCESS_CYCLES - 1);

    phase_e              phase_q, phase_d;
    logic [CNT_W-1:0]    wait_q, wait_d;
    logic [ROW_W-1:0]    row_q, row_d;
    logic [COL_BITS-1:0] col_q, col_d;
    logic                open_now;
    logic                row_hit, col_hit;

    assign row_hit = (row_in == row_q);
    assign col_hit = (col_in == col_q);

    always_comb begin
        phase_d  = phase_q;
        wait_d   = wait_q;
        row_d    = row_q;
        col_d    = col_q;
        open_now = 1'b0;
        unique case (phase_q)
            PH_CLOSED: begin
                if (req.sel) begin
                    open_now = 1'b1;
                end
            end
            PH_PRECH: begin
                if (wait_q != '0) begin
                    wait_d = wait_q - 1'b1;
                end else if (req.sel) begin
                    open_now = 1'b1;
                end else begin
                    phase_d = PH_CLOSED;
                end
            end
            PH_OPEN: begin
                if (!req.sel || !row_hit) begin
                    phase_d = PH_PRECH;
                    wait_d  = PRE_LOAD;
                end else if (!col_hit) begin
                    col_d  = col_in;
                    wait_d = (wait_q != '0) ? wait_q - 1'b1 : PAGE_LOAD;
                end else if (wait_q != '0) begin
                    wait_d = wait_q - 1'b1;
                end
            end
            default: phase_d = PH_CLOSED;
        endcase
        if (open_now) begin
            phase_d = PH_OPEN;
            row_d   = row_in;
            col_d   = col_in;
            wait_d  = ROW_LOAD;
        end
    end

    assign wr_en = (phase_q == PH_OPEN) && (wait_q == '0) && req.wr
                   && row_hit && col_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_CLOSED;
            wait_q     <= '0;
            row_q      <= '0;
            col_q      <= '0;
            data_valid <= 1'b0;
            act_stb    <= 1'b0;
            act_row    <= '0;
        end else begin
            phase_q    <= phase_d;
            wait_q     <= wait_d;
            row_q      <= row_d;
            col_q      <= col_d;
            data_valid <= (phase_d == PH_OPEN) && (wait_d == '0) && req.rd;
            act_stb    <= open_now;
            if (open_now) begin
                act_row <= row_in;
            end
        end
    end
endmodule

// File: rtl/rowbuf_mem.sv
module rowbuf_mem
    import rowbuf_pkg::*;
#(
    parameter int ADDR_W             = 11,
    parameter int DATA_W             = 8,
    parameter int PRECHARGE_CYCLES   = 3,
    parameter int ROW_ACCESS_CYCLES  = 2,
    parameter int PAGE_ACCESS_CYCLES = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ce_n,
    input  logic                       ce,
    input  logic                       oe_n,
    input  logic                       we_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic                       rdata_oe,
    output logic                       data_valid,
    output logic                       act_stb,
    output logic [ADDR_W-COL_BITS-1:0] act_row
);
    localparam int ROW_W = ADDR_W - COL_BITS;

    req_t              req;
    logic              wr_en;
    logic [DATA_W-1:0] rd_q;

    assign req      = decode_req(ce_n, ce, oe_n, we_n);
    assign rdata_oe = req.rd;

    rowbuf_ctrl #(
        .ROW_W             (ROW_W),
        .PRECHARGE_CYCLES  (PRECHARGE_CYCLES),
        .ROW_ACCESS_CYCLES (ROW_ACCESS_CYCLES),
        .PAGE_ACCESS_CYCLES(PAGE_ACCESS_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .row_in    (addr[ADDR_W-1:COL_BITS]),
        .col_in    (addr[COL_BITS-1:0]),
        .wr_en     (wr_en),
        .data_valid(data_valid),
        .act_stb   (act_stb),
        .act_row   (act_row)
    );

    rowbuf_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rd_q (rd_q)
    );

    assign rdata = data_valid ? rd_q : '0;
endmodule

// File: rtl/rowbuf_mem_chk.sv
module rowbuf_mem_chk #(
    parameter int ADDR_W            = 11,
    parameter int PRECHARGE_CYCLES  = 3,
    parameter int ROW_ACCESS_CYCLES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              ce,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              data_valid,
    input logic              act_stb,
    input logic [ADDR_W-4:0] act_row
);
    logic sel_in, rd_in;
    logic seen_act;
    int   since_act;

    assign sel_in = !ce_n && ce;
    assign rd_in  = sel_in && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_act  <= 1'b0;
            since_act <= 0;
        end else if (act_stb) begin
            seen_act  <= 1'b1;
            since_act <= 1;
        end else if (since_act < PRECHARGE_CYCLES + 2) begin
            since_act <= since_act + 1;
        end
    end

    // R2: an opening only follows an edge where the chip was selected
    a_r2_open_needs_select: assert property (@(posedge clk) disable iff (rst)
        act_stb |-> $past(sel_in));

    // R3: reported row is the upper address sampled at the opening edge
    a_r3_act_row_matches: assert property (@(posedge clk) disable iff (rst)
        act_stb |-> act_row == $past(addr[ADDR_W-1:3]));

    // R7: the strobe lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        act_stb |=> !act_stb);

    // R7 / R4: openings are separated by at least a full precharge
    a_r7_open_spacing: assert property (@(posedge clk) disable iff (rst)
        act_stb |-> (!seen_act || since_act >= PRECHARGE_CYCLES + 1));

    // R8 / R10: valid data only after a sampled read, never a write
    a_r10_valid_from_read: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $past(rd_in));

    // R1 / R5: an opening edge cannot also deliver data when row latency exceeds one
    a_r5_no_valid_on_open: assert property (@(posedge clk) disable iff (rst)
        (ROW_ACCESS_CYCLES > 1 && act_stb) |-> !data_valid);
endmodule

bind rowbuf_mem rowbuf_mem_chk #(
    .ADDR_W           (ADDR_W),
    .PRECHARGE_CYCLES (PRECHARGE_CYCLES),
    .ROW_ACCESS_CYCLES(ROW_ACCESS_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .ce        (ce),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .data_valid(data_valid),
    .act_stb   (act_stb),
    .act_row   (act_row)
);

// File: tb/rowbuf_mem_bench.sv
module rowbuf_mem_bench;
    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int PC  = 3;
    localparam int RAC = 2;
    localparam int PAC = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, ce = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe, data_valid, act_stb;
    logic [AW-4:0] act_row;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rowbuf_mem #(
        .ADDR_W(AW), .DATA_W(DW), .PRECHARGE_CYCLES(PC),
        .ROW_ACCESS_CYCLES(RAC), .PAGE_ACCESS_CYCLES(PAC)
    ) u_rowbuf_mem (
        .clk(clk), .rst(rst), .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .data_valid(data_valid), .act_stb(act_stb), .act_row(act_row)
    );

    // Behavioural reference: phase 0 closed, 1 precharging, 2 open
    int          m_phase, m_wait, m_row, m_col;
    bit          e_valid, e_act, e_known;
    int          e_row;
    logic [7:0]  e_data;
    logic [7:0]  m_mem [int];

    always @(posedge clk) begin
        bit s, rd, opening;
        int r, c, a;
        a  = int'(addr);
        r  = a / 8;
        c  = a % 8;
        s  = (ce_n == 1'b0) && (ce == 1'b1);
        rd = s && !oe_n && we_n;
        if (rst) begin
            m_phase = 0; m_wait = 0; m_row = 0; m_col = 0;
            e_valid = 0; e_act = 0; e_row = 0; e_known = 0; e_data = 0;
        end else begin
            opening = 0;
            if (m_phase == 2 && s && !we_n && r == m_row && c == m_col && m_wait == 0)
                m_mem[a] = wdata;
            if (m_phase == 0) begin
                opening = s;
            end else if (m_phase == 1) begin
                if (m_wait > 0) m_wait = m_wait - 1;
                else if (s) opening = 1;
                else m_phase = 0;
            end else begin
                if (!s || r != m_row) begin
                    m_phase = 1; m_wait = PC - 1;
                end else if (c != m_col) begin
                    m_col  = c;
                    m_wait = (m_wait > 0) ? m_wait - 1 : PAC - 1;
                end else if (m_wait > 0) begin
                    m_wait = m_wait - 1;
                end
            end
            if (opening) begin
                m_phase = 2; m_row = r; m_col = c; m_wait = RAC - 1; e_row = r;
            end
            e_act   = opening;
            e_valid = (m_phase == 2) && (m_wait == 0) && rd;
            e_known = e_valid && m_mem.exists(a);
            e_data  = e_known ? m_mem[a] : 8'h00;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_oe;
        exp_oe = !ce_n && ce && !oe_n && we_n;
        check(data_valid == e_valid, "R10 data_valid vs model", int'(data_valid), int'(e_valid));
        check(act_stb == e_act, "R7 act_stb vs model", int'(act_stb), int'(e_act));
        if (e_act) check(int'(act_row) == e_row, "R3 act_row", int'(act_row), e_row);
        check(rdata_oe == exp_oe, "R9 rdata_oe", int'(rdata_oe), int'(exp_oe));
        if (e_valid && e_known) check(rdata == e_data, "R8 rdata vs model", int'(rdata), int'(e_data));
        if (!data_valid) check(rdata == 8'h00, "R10 rdata idle zero", int'(rdata), 0);
    endtask

    task automatic tick(input logic cn, input logic c, input logic on, input logic wn,
                        input int a, input int d);
        ce_n = cn; ce = c; oe_n = on; we_n = wn;
        addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1, 0, 1, 1, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        for (int i = 0; i < PC + RAC + 3; i++) tick(0, 1, 1, 0, a, d);
    endtask

    task automatic measure(input int a, output int n);
        n = 0;
        do begin
            tick(0, 1, 0, 1, a, 0);
            n++;
        end while (!data_valid && n < 40);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        int n;
        bit any_act;
        idle(3);
        check(data_valid == 1'b0 && act_stb == 1'b0 && rdata == 8'h00, "R1 reset outputs",
              int'(data_valid) + int'(act_stb), 0);
        rst = 1'b0;
        idle(2);

        for (int i = 0; i < 8; i++) wr(16 + i, int'(pat(16 + i)));
        for (int i = 0; i < 4; i++) wr(32 + i, int'(pat(32 + i)));
        idle(PC + 1);

        measure(18, n);
        check(n == RAC, "R1 cold row latency", n, RAC);
        check(rdata == pat(18), "R3 cold read data", int'(rdata), int'(pat(18)));

        any_act = 0;
        measure(21, n);
        any_act |= act_stb;
        check(n == PAC, "R6 page latency col 5", n, PAC);
        check(rdata == pat(21), "R6 page data col 5", int'(rdata), int'(pat(21)));
        measure(17, n);
        any_act |= act_stb;
        check(n == PAC, "R6 page latency col 1", n, PAC);
        measure(23, n);
        any_act |= act_stb;
        check(n == PAC, "R6 page latency col 7", n, PAC);
        check(rdata == pat(23), "R6 page data col 7", int'(rdata), int'(pat(23)));
        check(!any_act, "R6 no activation on page hits", int'(any_act), 0);

        measure(33, n);
        check(n == PC + RAC, "R5 row change latency", n, PC + RAC);
        check(rdata == pat(33), "R5 row change data", int'(rdata), int'(pat(33)));

        tick(1, 0, 1, 1, 33, 0);
        measure(34, n);
        check(n == PC + RAC - 1, "R4 early reselect waits out precharge", n, PC + RAC - 1);
        check(rdata == pat(34), "R4 data after precharge", int'(rdata), int'(pat(34)));

        idle(PC + 1);
        any_act = 0;
        for (int i = 0; i < 4; i++) begin tick(1, 1, 0, 1, 35, 0); any_act |= act_stb; end
        for (int i = 0; i < 4; i++) begin tick(0, 0, 0, 1, 35, 0); any_act |= act_stb; end
        check(!any_act, "R2 half select opens nothing", int'(any_act), 0);
        measure(35, n);
        check(n == RAC, "R2 full select opens row", n, RAC);

        for (int i = 0; i < 3; i++) tick(0, 1, 0, 0, 35, 8'h5A);
        check(rdata_oe == 1'b0 && data_valid == 1'b0, "R8 write overrides output enable",
              int'(rdata_oe) + int'(data_valid), 0);
        measure(35, n);
        check(n == 1 && rdata == 8'h5A, "R8 readback after write", int'(rdata), 8'h5A);

        tick(0, 1, 1, 1, 35, 0);
        check(rdata_oe == 1'b0 && data_valid == 1'b0, "R9 output enable high",
              int'(rdata_oe) + int'(data_valid), 0);

        idle(4);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule